// File: doc/BRIEF.md
# Game Controller Serial Poller

This block talks to a hand-held game controller over one shared open-drain data wire. It polls without pause. After an idle gap it sends a fixed command byte and then releases the wire. It then collects the controller's 32-bit status reply bit by bit. When a reply is complete, it presents the button flags and two signed joystick axes to the rest of the chip.

Each bit crosses the wire as a pulse-width cell made of four equal quarters. The host never drives the wire high. It pulls the wire low to send a zero level and releases it to send a one level. The quarter length is a parameter, one microsecond at the 27 MHz system clock by default. If a reply stops partway through, the poller drops that reply, keeps its old outputs and starts a new poll.

Top module: `pad_poller`

## Requirements
- R1: The poller runs without stopping. Each transaction, whether it completes or times out, is followed by an idle gap of GAP_CELLS cells and then a new command.
- R2: A command bit cell lasts four quarters of QUARTER_CYC clocks each. In the first quarter the host pulls the wire low. In quarters two and three the wire carries the bit value. In the fourth quarter the wire is released. The command is POLL_CMD, sent most significant bit first.
- R3: After the eighth command bit, the host sends a stop cell: the wire is low for two quarters and released for two. The host pulls the wire low (line_oe=1) only while it sends the command and its stop cell.
- R4: Each reply bit is taken as the level of the wire two quarters after that bit's falling edge. Thirty-two bits are collected, and the first bit received becomes bit 31.
- R5: In the collected reply, bits 31:16 are the button flags, bits 15:8 are the signed horizontal axis and bits 7:0 are the signed vertical axis (two's complement).
- R6: The buttons, stick_x and stick_y outputs all change together. They change only in the cycle where frame_upd is high. frame_upd is a single-cycle pulse that follows each complete 32-bit reply.
- R7: If no falling edge arrives for TIMEOUT_CELLS cells during a reply, the reply is abandoned. In that case frame_upd stays low and the outputs keep their previous values.
- R8: While reset is held, line_oe is 0, frame_upd is 0 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (27 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level seen on the shared data wire |
| line_oe | output | 1 | 1 pulls the wire low, 0 releases it |
| buttons | output | RESP_W-2*AXIS_W | Latched button flags |
| stick_x | output | AXIS_W | Latched signed horizontal axis |
| stick_y | output | AXIS_W | Latched signed vertical axis |
| frame_upd | output | 1 | One-cycle pulse when new values are latched |

## Verification
A wrong quarter or cell counter in the transmitter shows up on line_oe within the first command cell, as a misplaced low or released level at a mid-quarter sample. A wrong bit count or a wrong sample point in the receiver shows up at the next frame_upd: the pulse is missing, early or extra, or the latched fields are shifted against the reply that was sent. A broken timeout path shows up within one transaction. Either the poll after a truncated reply never starts, or a spurious update appears that the scoreboard has no entry for.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;
   typedef enum logic [1:0] {
      PH_GAP = 2'd0,
      PH_TX  = 2'd1,
      PH_RX  = 2'd2
   } poll_phase_t;
endpackage

// File: rtl/pad_tx_serial.sv
module pad_tx_serial #(
   parameter int CMD_W       = 8,
   parameter int QUARTER_CYC = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CMD_W-1:0] cmd,
   output logic             oe,
   output logic             done
);
   localparam int CW = $clog2(QUARTER_CYC);
   localparam int BW = $clog2(CMD_W + 1);

   generate
      if (QUARTER_CYC < 4) begin : g_bad_quarter
         $error("pad_tx_serial: QUARTER_CYC must be at least 4");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("pad_tx_serial: CMD_W must be at least 2");
      end
   endgenerate

   logic             active;
   logic [CW-1:0]    cyc;
   logic [1:0]       qtr;
   logic [BW-1:0]    bidx;
   logic [CMD_W-1:0] sh;
   logic             q_end;
   logic             is_stop;

   assign q_end   = (cyc == CW'(QUARTER_CYC - 1));
   assign is_stop = (bidx == BW'(CMD_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cyc    <= '0;
         qtr    <= '0;
         bidx   <= '0;
         sh     <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go && !active) begin
            active <= 1'b1;
            cyc    <= '0;
            qtr    <= '0;
            bidx   <= '0;
            sh     <= cmd;
         end else if (active) begin
            if (q_end) begin
               cyc <= '0;
               qtr <= qtr + 2'd1;
               if (qtr == 2'd3) begin
                  if (is_stop) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     bidx <= bidx + BW'(1);
                     sh   <= {sh[CMD_W-2:0], 1'b0};
                  end
               end
            end else begin
               cyc <= cyc + CW'(1);
            end
         end
      end
   end

   // quarter 0 low; data cells carry the bit in quarters 1-2; stop cell low through quarter 1
   always_comb begin
      oe = 1'b0;
      if (active) begin
         unique case (qtr)
            2'd0:    oe = 1'b1;
            2'd1:    oe = is_stop | ~sh[CMD_W-1];
            2'd2:    oe = ~is_stop & ~sh[CMD_W-1];
            default: oe = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/pad_rx_capture.sv
module pad_rx_capture #(
   parameter int RESP_W      = 32,
   parameter int QUARTER_CYC = 27,
   parameter int TIMEOUT_CYC = 432,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              line_s,
   output logic              done,
   output logic              abort,
   output logic [RESP_W-1:0] data
);
   localparam int SMP = 2 * QUARTER_CYC;
   localparam int SW  = $clog2(SMP + 1);
   localparam int TW  = $clog2(TIMEOUT_CYC + 1);
   localparam int NW  = $clog2(RESP_W + 1);

   generate
      if (TIMEOUT_CYC <= 4 * QUARTER_CYC) begin : g_bad_timeout
         $error("pad_rx_capture: timeout must exceed one bit cell");
      end
   endgenerate

   logic              active;
   logic              line_d;
   logic              in_cell;
   logic [SW-1:0]     smp_cnt;
   logic [TW-1:0]     wait_cnt;
   logic [NW-1:0]     nbits;
   logic [RESP_W-1:0] sh_next;
   logic              fall;

   assign fall = line_d & ~line_s;
   assign data = sh_next_hold;

   logic [RESP_W-1:0] sh_next_hold;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_next_hold[RESP_W-2:0], line_s};
      end else begin : g_lsb
         assign sh_next = {line_s, sh_next_hold[RESP_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active       <= 1'b0;
         line_d       <= 1'b1;
         in_cell      <= 1'b0;
         smp_cnt      <= '0;
         wait_cnt     <= '0;
         nbits        <= '0;
         sh_next_hold <= '0;
         done         <= 1'b0;
         abort        <= 1'b0;
      end else begin
         line_d <= line_s;
         done   <= 1'b0;
         abort  <= 1'b0;
         if (arm && !active) begin
            active   <= 1'b1;
            in_cell  <= 1'b0;
            wait_cnt <= '0;
            nbits    <= '0;
         end else if (active) begin
            if (fall) begin
               in_cell  <= 1'b1;
               smp_cnt  <= '0;
               wait_cnt <= '0;
            end else begin
               if (wait_cnt == TW'(TIMEOUT_CYC - 1)) begin
                  active  <= 1'b0;
                  abort   <= 1'b1;
                  in_cell <= 1'b0;
               end else begin
                  wait_cnt <= wait_cnt + TW'(1);
               end
               if (in_cell) begin
                  if (smp_cnt == SW'(SMP - 1)) begin
                     sh_next_hold <= sh_next;
                     in_cell      <= 1'b0;
                     nbits        <= nbits + NW'(1);
                     if (nbits == NW'(RESP_W - 1)) begin
                        done   <= 1'b1;
                        active <= 1'b0;
                     end
                  end else begin
                     smp_cnt <= smp_cnt + SW'(1);
                  end
               end
            end
         end
      end
   end

   assert_nbits_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (nbits < NW'(RESP_W)));
endmodule

// File: rtl/pad_poller.sv
module pad_poller #(
   parameter int QUARTER_CYC   = 27,
   parameter int CMD_W         = 8,
   parameter int RESP_W        = 32,
   parameter int AXIS_W        = 8,
   parameter int POLL_CMD      = 1,
   parameter int TIMEOUT_CELLS = 4,
   parameter int GAP_CELLS     = 16,
   parameter bit MSB_FIRST     = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             line_in,
   output logic                             line_oe,
   output logic [RESP_W-2*AXIS_W-1:0]       buttons,
   output logic signed [AXIS_W-1:0]         stick_x,
   output logic signed [AXIS_W-1:0]         stick_y,
   output logic                             frame_upd
);
   import pad_poll_pkg::*;

   localparam int BTN_W       = RESP_W - 2 * AXIS_W;
   localparam int CELL_CYC    = 4 * QUARTER_CYC;
   localparam int TIMEOUT_CYC = TIMEOUT_CELLS * CELL_CYC;
   localparam int GAP_CYC     = GAP_CELLS * CELL_CYC;
   localparam int GW          = $clog2(GAP_CYC + 1);

   generate
      if (BTN_W < 1) begin : g_bad_resp
         $error("pad_poller: RESP_W must exceed two axis fields");
      end
      if (GAP_CELLS < 2) begin : g_bad_gap
         $error("pad_poller: GAP_CELLS must be at least 2");
      end
   endgenerate

   poll_phase_t       phase;
   logic [GW-1:0]     gap_cnt;
   logic [1:0]        sync;
   logic              tx_go, tx_done;
   logic              rx_done, rx_abort;
   logic [RESP_W-1:0] rx_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= 2'b11;
      else        sync <= {sync[0], line_in};
   end

   assign tx_go = (phase == PH_GAP) && (gap_cnt == GW'(GAP_CYC - 1));

   pad_tx_serial #(.CMD_W(CMD_W), .QUARTER_CYC(QUARTER_CYC)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (tx_go),
      .cmd  (CMD_W'(POLL_CMD)),
      .oe   (line_oe),
      .done (tx_done)
   );

   pad_rx_capture #(
      .RESP_W     (RESP_W),
      .QUARTER_CYC(QUARTER_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC),
      .MSB_FIRST  (MSB_FIRST)
   ) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (tx_done),
      .line_s(sync[1]),
      .done  (rx_done),
      .abort (rx_abort),
      .data  (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_GAP;
         gap_cnt   <= '0;
         buttons   <= '0;
         stick_x   <= '0;
         stick_y   <= '0;
         frame_upd <= 1'b0;
      end else begin
         frame_upd <= 1'b0;
         unique case (phase)
            PH_GAP: begin
               if (tx_go) begin
                  phase   <= PH_TX;
                  gap_cnt <= '0;
               end else begin
                  gap_cnt <= gap_cnt + GW'(1);
               end
            end
            PH_TX: if (tx_done) phase <= PH_RX;
            PH_RX: begin
               if (rx_done) begin
                  buttons   <= rx_data[RESP_W-1 -: BTN_W];
                  stick_x   <= rx_data[2*AXIS_W-1 -: AXIS_W];
                  stick_y   <= rx_data[AXIS_W-1:0];
                  frame_upd <= 1'b1;
                  phase     <= PH_GAP;
                  gap_cnt   <= '0;
               end else if (rx_abort) begin
                  phase   <= PH_GAP;
                  gap_cnt <= '0;
               end
            end
            default: phase <= PH_GAP;
         endcase
      end
   end

   assert_drive_only_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> (phase == PH_TX));
   assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_upd |-> $stable({buttons, stick_x, stick_y}));
   assert_upd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_upd |=> !frame_upd);
   assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_abort |=> !frame_upd);
endmodule

// File: tb/pad_poller_bench.sv
`timescale 1ns/1ps
module pad_poller_bench;
   localparam int Q    = 4;
   localparam int CELL = 4 * Q;
   localparam logic [7:0] CMD = 8'h96;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dev_pull = 1'b0;
   logic line_oe, frame_upd, line;
   logic [15:0] buttons;
   logic signed [7:0] stick_x, stick_y;

   always #2.5 clk = ~clk;

   assign line = ~(line_oe | dev_pull);

   pad_poller #(
      .QUARTER_CYC(Q), .CMD_W(8), .RESP_W(32), .AXIS_W(8),
      .POLL_CMD(int'(CMD)), .TIMEOUT_CELLS(3), .GAP_CELLS(8), .MSB_FIRST(1'b1)
   ) u_pad_poller (
      .clk(clk), .rst_n(rst_n), .line_in(line), .line_oe(line_oe),
      .buttons(buttons), .stick_x(stick_x), .stick_y(stick_y), .frame_upd(frame_upd)
   );

   int n_checks = 0;
   int n_errs   = 0;
   logic [31:0] exp_q[$];
   int pos;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   endtask

   task automatic goto_pos(input int target);
      repeat (target - pos) @(negedge clk);
      pos = target;
   endtask

   // monitor: pops the scoreboard on each update pulse
   always @(negedge clk) begin
      if (rst_n && frame_upd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "update without full reply", {buttons, stick_x, stick_y}, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk({buttons, stick_x, stick_y} == e, "R5", "latched fields", {buttons, stick_x, stick_y}, e);
         end
      end
   end

   // waits for the host to start a command, then checks each cell
   task automatic capture_cmd(input logic [31:0] hold_exp);
      @(negedge clk);
      while (!line_oe) @(negedge clk);
      pos = 0;
      chk({buttons, stick_x, stick_y} == hold_exp, "R7", "outputs held at poll start",
          {buttons, stick_x, stick_y}, hold_exp);
      chk(1'b1, "R1", "new poll started", 32'h1, 32'h1);
      for (int k = 0; k < 8; k++) begin
         goto_pos(CELL * k + Q / 2);
         chk(line == 1'b0, "R2", "cell start low", {31'h0, line}, 32'h0);
         goto_pos(CELL * k + 2 * Q);
         chk(line == CMD[7-k], "R2", "command bit", {31'h0, line}, {31'h0, CMD[7-k]});
         goto_pos(CELL * k + 3 * Q + Q / 2);
         chk(line == 1'b1, "R2", "cell end released", {31'h0, line}, 32'h1);
      end
      goto_pos(CELL * 8 + Q + Q / 2);
      chk(line == 1'b0, "R3", "stop cell low", {31'h0, line}, 32'h0);
      goto_pos(CELL * 8 + 3 * Q);
      chk(line_oe == 1'b0, "R3", "wire released after stop", {31'h0, line_oe}, 32'h0);
      goto_pos(CELL * 9 + 2 * Q);
   endtask

   task automatic send_reply(input logic [31:0] r, input int nb);
      for (int i = 31; i > 31 - nb; i--) begin
         dev_pull = 1'b1;
         repeat (Q) @(negedge clk);
         dev_pull = ~r[i];
         repeat (2 * Q) @(negedge clk);
         dev_pull = 1'b0;
         repeat (Q) @(negedge clk);
      end
      if (nb == 32) begin
         dev_pull = 1'b1;
         repeat (Q) @(negedge clk);
         dev_pull = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] last_good;
      logic [31:0] resp [6];
      int nbits [6];
      resp[0] = 32'h1000_05FD; nbits[0] = 32;
      resp[1] = 32'hFFFF_807F; nbits[1] = 32;
      resp[2] = 32'h0F0F_3355; nbits[2] = 20;
      resp[3] = 32'h0000_0000; nbits[3] = 0;
      resp[4] = 32'hA5C3_01FF; nbits[4] = 32;
      resp[5] = 32'h0000_0000; nbits[5] = 32;
      last_good = 32'h0;

      repeat (4) @(negedge clk);
      chk(line_oe == 1'b0, "R8", "reset line_oe", {31'h0, line_oe}, 32'h0);
      chk(frame_upd == 1'b0, "R8", "reset frame_upd", {31'h0, frame_upd}, 32'h0);
      chk({buttons, stick_x, stick_y} == 32'h0, "R8", "reset outputs",
          {buttons, stick_x, stick_y}, 32'h0);
      rst_n = 1'b1;

      for (int t = 0; t < 6; t++) begin
         capture_cmd(last_good);
         if (nbits[t] == 32) begin
            exp_q.push_back(resp[t]);   // R4 / R6: one update expected per full reply
            last_good = resp[t];
         end
         send_reply(resp[t], nbits[t]);
      end
      capture_cmd(last_good);
      chk(exp_q.size() == 0, "R6", "all full replies produced an update",
          exp_q.size(), 32'h0);
      chk(stick_x == 8'sd0 && stick_y == 8'sd0, "R5", "zero axes after last frame",
          {16'h0, stick_x, stick_y}, 32'h0);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule